// File: doc/BRIEF.md
# Tagged Burst Read Responder

This block sits on the memory-controller side of a read channel shared by two cache banks. Each bank raises a request strobe with a 3-bit tag, a line address and a dummy flag. The block checks the request against the per-bank rules. A legal request gets a one-cycle acknowledge. An illegal one gets a protocol-error pulse. Accepted requests pass through a fixed-latency behavioural memory. Each accepted line then returns as four 128-bit beats on one shared response bus. The bus carries a per-bank valid strobe, the echoed tag and the index of the beat on the bus.

Address bit 5 marks which half of the 64-byte line the requester needs first, and the block rotates the beat order to match. A dummy request travels the same path and is counted as outstanding. It returns four beats of zero and never reads the array.

The stored line pattern is computed, not loaded. In lane k (32 bits each, lane 0 in the least significant bits) of beat b of line L, the word is {8'hA5, L, b, k}, with each field 8 bits wide. The line index is taken from address bits 9:6.

Top module: `burst_read_responder`

## Requirements
- R1: A legal request from a bank produces exactly one acknowledge cycle on that bank's `rd_ack` bit, in the cycle after the request is sampled. After reset, `rd_ack`, `proto_err` and `rsp_vld` are all zero.
- R2: A bank may hold at most MAX_OUT (8) outstanding requests, dummies included. A further request from that bank is rejected with a `proto_err` pulse and no acknowledge.
- R3: A request whose tag is still outstanding on the same bank is rejected with a `proto_err` pulse and no acknowledge, and it never produces response beats.
- R4: `rsp_tag` carries the request's tag during all four beats of its response.
- R5: With address bit 5 equal to 0, `rsp_beat` runs 0,1,2,3. With address bit 5 equal to 1, it runs 2,3,0,1.
- R6: The four beats of a response occupy four consecutive cycles, with exactly one `rsp_vld` bit set, and they are never interleaved with another response. The fourth beat frees the tag, so it can be reused.
- R7: Every beat of a dummy request carries all-zero data.
- R8: A non-dummy beat carries the computed line pattern for its line and beat index.
- R9: On an idle block, the first beat appears MEM_LAT+1 cycles after the acknowledge cycle.
- R10: When both banks have a line ready in the same cycle, bank 0 is served first.
- R11: A request from a bank that arrives fewer than MIN_GAP+1 cycles after that bank's previous accepted request is rejected with a `proto_err` pulse and no acknowledge.
- R12: Both banks may request in the same cycle, and both are acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 2 | Read request strobe, one bit per bank |
| rd_tag | input | 6 | 3-bit tag per bank, bank 0 in bits 2:0 |
| rd_addr | input | 20 | 10-bit line address per bank; bit 5 picks the order, bits 9:6 pick the line |
| rd_dummy | input | 2 | Dummy flag per bank |
| rd_ack | output | 2 | One-cycle acknowledge per bank |
| proto_err | output | 2 | One-cycle rejection pulse per bank |
| rsp_vld | output | 2 | Response beat valid, one bit per bank |
| rsp_tag | output | 3 | Tag of the beat on the bus |
| rsp_beat | output | 2 | Beat index of the beat on the bus |
| rsp_data | output | 128 | Beat data |

## Verification
Two pairs of functions can meet in one cycle. The first pair is request intake on both banks and the return of ready lines from both banks to the single beat engine. The bench drives both banks in the same cycle and checks that both acknowledges rise together. It then checks that the recorded beat stream holds all four bank-0 beats before any bank-1 beat. The second pair is the cap check and the arbitration. Bank 0 is kept busy at the full request rate, which starves bank 1 while bank 1 fills its eight tags. Bank 1's ninth request is then judged for rejection, and its eight lines are judged for draining in tag order once bank 0 stops.

// File: rtl/brr_pkg.sv
package brr_pkg;

  localparam int TAG_W     = 3;
  localparam int LINE_W    = 4;
  localparam int ORDER_BIT = 5;
  localparam int LINE_LSB  = 6;
  localparam int ADDR_W    = LINE_LSB + LINE_W;
  localparam int DATA_W    = 128;
  localparam int LANE_W    = 32;
  localparam int BEATS     = 4;
  localparam int BEAT_W    = $clog2(BEATS);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [LINE_W-1:0] line;
    logic              order;
    logic              dummy;
  } rd_entry_t;

  // Beat index on the bus for a given position within the burst.
  function automatic logic [BEAT_W-1:0] beat_index(logic [BEAT_W-1:0] pos, logic order);
    return pos ^ {order, {(BEAT_W-1){1'b0}}};
  endfunction

  // Behavioural line store: content is computed from line and beat.
  function automatic logic [DATA_W-1:0] line_word(logic [LINE_W-1:0] line,
                                                  logic [BEAT_W-1:0] beat);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int k = 0; k < DATA_W / LANE_W; k++)
      w[k*LANE_W +: LANE_W] = {8'hA5, 8'(line), 8'(beat), 8'(k)};
    return w;
  endfunction

endpackage

// File: rtl/brr_bank_front.sv
module brr_bank_front
  import brr_pkg::*;
#(
  parameter int MEM_LAT = 4,
  parameter int MIN_GAP = 3,
  parameter int MAX_OUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [TAG_W-1:0]  tag,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dummy,
  input  logic              pop,
  input  logic              done,
  input  logic [TAG_W-1:0]  done_tag,
  output logic              ack,
  output logic              err,
  output rd_entry_t         head,
  output logic              head_vld
);

  localparam int NTAGS = 1 << TAG_W;
  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam int PTR_W = $clog2(MAX_OUT);

  logic [NTAGS-1:0] busy_tags;
  logic [CNT_W-1:0] n_out;
  logic [GAP_W-1:0] gap_cnt;

  // Named intake events
  logic dup_hit, full_hit, gap_hit, accept;
  logic unused_low_addr;

  assign n_out    = CNT_W'($countones(busy_tags));
  assign dup_hit  = req && busy_tags[tag];
  assign full_hit = req && (n_out >= CNT_W'(MAX_OUT));
  assign gap_hit  = req && (gap_cnt != '0);
  assign accept   = req && !dup_hit && !full_hit && !gap_hit;
  assign unused_low_addr = ^addr[ORDER_BIT-1:0];

  rd_entry_t new_ent;
  always_comb begin
    new_ent.tag   = tag;
    new_ent.line  = addr[LINE_LSB +: LINE_W];
    new_ent.order = addr[ORDER_BIT];
    new_ent.dummy = dummy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack     <= 1'b0;
      err     <= 1'b0;
      gap_cnt <= '0;
    end else begin
      ack <= accept;
      err <= req && !accept;
      if (accept)              gap_cnt <= GAP_W'(MIN_GAP);
      else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_tags <= '0;
    end else begin
      for (int t = 0; t < NTAGS; t++)
        busy_tags[t] <= (busy_tags[t] && !(done && done_tag == TAG_W'(t))) ||
                        (accept && tag == TAG_W'(t));
    end
  end

  // Fixed-latency memory pipeline
  logic      pipe_vld [MEM_LAT];
  rd_entry_t pipe_ent [MEM_LAT];

  for (genvar s = 0; s < MEM_LAT; s++) begin : g_lat
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_vld[0] <= 1'b0;
        else        pipe_vld[0] <= accept;
        pipe_ent[0] <= new_ent;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe_vld[s] <= 1'b0;
        else        pipe_vld[s] <= pipe_vld[s-1];
        pipe_ent[s] <= pipe_ent[s-1];
      end
    end
  end

  // Ready queue
  logic             push;
  rd_entry_t        q_mem [MAX_OUT];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] occ;

  assign push     = pipe_vld[MEM_LAT-1];
  assign head     = q_mem[rd_ptr];
  assign head_vld = (occ != '0);

  always_ff @(posedge clk) begin
    if (push) q_mem[wr_ptr] <= pipe_ent[MEM_LAT-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(MAX_OUT-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(MAX_OUT-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assert_ack_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_ack_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));
  assert_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    n_out <= CNT_W'(MAX_OUT));
  assert_queue_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (occ < CNT_W'(MAX_OUT)));
  assert_dup_rejected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dup_hit |=> (err && !ack));
  assert_gap_rejected_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gap_hit |=> (err && !ack));

endmodule

// File: rtl/brr_beat_engine.sv
module brr_beat_engine
  import brr_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rd_entry_t             head     [NUM_BANKS],
  input  logic [NUM_BANKS-1:0]  head_vld,
  output logic [NUM_BANKS-1:0]  pop,
  output logic [NUM_BANKS-1:0]  done,
  output logic [TAG_W-1:0]      done_tag,
  output logic [NUM_BANKS-1:0]  rsp_vld,
  output logic [TAG_W-1:0]      rsp_tag,
  output logic [BEAT_W-1:0]     rsp_beat,
  output logic [DATA_W-1:0]     rsp_data
);

  localparam int SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              busy;
  logic [BEAT_W-1:0] pos;
  logic [SEL_W-1:0]  sel;
  rd_entry_t         cur;

  // Named engine events
  logic             found, last_beat, load;
  logic [SEL_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (head_vld[b]) begin
        found = 1'b1;
        pick  = SEL_W'(b);
      end
    end
  end

  assign last_beat = busy && (pos == BEAT_W'(BEATS - 1));
  assign load      = found && (!busy || last_beat);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pos  <= '0;
      sel  <= '0;
      cur  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      pos  <= '0;
      sel  <= pick;
      cur  <= head[pick];
    end else if (last_beat) begin
      busy <= 1'b0;
    end else if (busy) begin
      pos <= pos + 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign pop[b]     = load && (pick == SEL_W'(b));
    assign done[b]    = last_beat && (sel == SEL_W'(b));
    assign rsp_vld[b] = busy && (sel == SEL_W'(b));
  end

  assign done_tag = cur.tag;
  assign rsp_tag  = busy ? cur.tag : '0;
  assign rsp_beat = busy ? beat_index(pos, cur.order) : '0;
  assign rsp_data = (busy && !cur.dummy) ? line_word(cur.line, rsp_beat) : '0;

  assert_one_bank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_vld));
  assert_no_interleave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_beat) |=> (busy && $stable(sel) && $stable(rsp_tag)));
  assert_beat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_beat) |=> (rsp_beat == BEAT_W'($past(rsp_beat) + 1'b1)));
  assert_dummy_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur.dummy) |-> (rsp_data == '0));
  assert_bank0_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && head_vld[0]) |-> pop[0]);

endmodule

// File: rtl/burst_read_responder.sv
module burst_read_responder
  import brr_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int MEM_LAT   = 4,
  parameter int MIN_GAP   = 3,
  parameter int MAX_OUT   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_BANKS-1:0]          rd_req,
  input  logic [NUM_BANKS*TAG_W-1:0]    rd_tag,
  input  logic [NUM_BANKS*ADDR_W-1:0]   rd_addr,
  input  logic [NUM_BANKS-1:0]          rd_dummy,
  output logic [NUM_BANKS-1:0]          rd_ack,
  output logic [NUM_BANKS-1:0]          proto_err,
  output logic [NUM_BANKS-1:0]          rsp_vld,
  output logic [TAG_W-1:0]              rsp_tag,
  output logic [BEAT_W-1:0]             rsp_beat,
  output logic [DATA_W-1:0]             rsp_data
);

  rd_entry_t            head_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] head_vld_w, pop_w, done_w;
  logic [TAG_W-1:0]     done_tag_w;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_front
    brr_bank_front #(
      .MEM_LAT (MEM_LAT),
      .MIN_GAP (MIN_GAP),
      .MAX_OUT (MAX_OUT)
    ) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (rd_req[b]),
      .tag      (rd_tag[b*TAG_W +: TAG_W]),
      .addr     (rd_addr[b*ADDR_W +: ADDR_W]),
      .dummy    (rd_dummy[b]),
      .pop      (pop_w[b]),
      .done     (done_w[b]),
      .done_tag (done_tag_w),
      .ack      (rd_ack[b]),
      .err      (proto_err[b]),
      .head     (head_w[b]),
      .head_vld (head_vld_w[b])
    );
  end

  brr_beat_engine #(.NUM_BANKS(NUM_BANKS)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .head     (head_w),
    .head_vld (head_vld_w),
    .pop      (pop_w),
    .done     (done_w),
    .done_tag (done_tag_w),
    .rsp_vld  (rsp_vld),
    .rsp_tag  (rsp_tag),
    .rsp_beat (rsp_beat),
    .rsp_data (rsp_data)
  );

  assert_ack_err_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack & proto_err) == '0);

endmodule

// File: tb/burst_read_responder_test.sv
module burst_read_responder_test;

  localparam int LAT = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   rd_req = '0;
  logic [5:0]   rd_tag = '0;
  logic [19:0]  rd_addr = '0;
  logic [1:0]   rd_dummy = '0;
  logic [1:0]   rd_ack, proto_err, rsp_vld;
  logic [2:0]   rsp_tag;
  logic [1:0]   rsp_beat;
  logic [127:0] rsp_data;

  burst_read_responder uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_tag(rd_tag),
    .rd_addr(rd_addr), .rd_dummy(rd_dummy), .rd_ack(rd_ack),
    .proto_err(proto_err), .rsp_vld(rsp_vld), .rsp_tag(rsp_tag),
    .rsp_beat(rsp_beat), .rsp_data(rsp_data)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Response recorder
  int           mon_n = 0;
  int           mon_bank [128];
  logic [2:0]   mon_tag  [128];
  logic [1:0]   mon_beat [128];
  logic [127:0] mon_data [128];
  int           mon_cyc  [128];

  always @(negedge clk) begin
    if (rsp_vld != 2'b00 && mon_n < 128) begin
      mon_bank[mon_n] = rsp_vld[1] ? 1 : 0;
      mon_tag[mon_n]  = rsp_tag;
      mon_beat[mon_n] = rsp_beat;
      mon_data[mon_n] = rsp_data;
      mon_cyc[mon_n]  = cyc;
      mon_n = mon_n + 1;
    end
  end

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_word(input logic [3:0] l, input logic [1:0] b);
    return {8'hA5, 4'h0, l, 6'h0, b, 8'd3,
            8'hA5, 4'h0, l, 6'h0, b, 8'd2,
            8'hA5, 4'h0, l, 6'h0, b, 8'd1,
            8'hA5, 4'h0, l, 6'h0, b, 8'd0};
  endfunction

  task automatic send(input int b, input logic [2:0] t, input logic [3:0] l,
                      input logic o, input logic d);
    rd_req[b] = 1'b1;
    rd_tag[b*3 +: 3] = t;
    rd_addr[b*10 +: 10] = {l, o, 5'b0};
    rd_dummy[b] = d;
  endtask

  task automatic idle_inputs();
    rd_req = '0;
    rd_dummy = '0;
  endtask

  // {bank, tag[2:0], line[3:0], order, dummy}
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 3'd1, 4'd3,  1'b0, 1'b0},
    {1'b0, 3'd2, 4'd9,  1'b1, 1'b0},
    {1'b1, 3'd4, 4'd5,  1'b0, 1'b0},
    {1'b1, 3'd7, 4'd15, 1'b1, 1'b0},
    {1'b0, 3'd3, 4'd6,  1'b1, 1'b1},
    {1'b1, 3'd0, 4'd0,  1'b0, 1'b1}
  };

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ack_cyc;
    int base;
    repeat (4) @(negedge clk);
    chk("R1 reset ack", 128'(rd_ack), 128'(0));
    chk("R1 reset err", 128'(proto_err), 128'(0));
    chk("R6 reset vld", 128'(rsp_vld), 128'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector walk
    for (int v = 0; v < 6; v++) begin
      int b;
      logic [2:0] t; logic [3:0] l; logic o, d;
      b = int'(VEC[v][9]); t = VEC[v][8:6]; l = VEC[v][5:2]; o = VEC[v][1]; d = VEC[v][0];
      mon_n = 0;
      send(b, t, l, o, d);
      @(negedge clk);
      idle_inputs();
      chk("R1 ack", 128'(rd_ack), 128'(2'b01 << b));
      chk("R1 no err", 128'(proto_err), 128'(0));
      ack_cyc = cyc;
      @(negedge clk);
      chk("R1 pulse", 128'(rd_ack), 128'(0));
      repeat (12) @(negedge clk);
      chk("R6 beat count", 128'(mon_n), 128'(4));
      chk("R9 latency", 128'(mon_cyc[0] - ack_cyc), 128'(LAT + 1));
      for (int i = 0; i < 4; i++) begin
        logic [1:0] eb;
        eb = o ? 2'((i + 2) % 4) : 2'(i);
        chk("R6 bank", 128'(mon_bank[i]), 128'(b));
        chk("R6 consecutive", 128'(mon_cyc[i] - mon_cyc[0]), 128'(i));
        chk("R4 tag", 128'(mon_tag[i]), 128'(t));
        chk("R5 order", 128'(mon_beat[i]), 128'(eb));
        if (d) chk("R7 zero data", mon_data[i], 128'(0));
        else   chk("R8 data", mon_data[i], exp_word(l, eb));
      end
    end

    // Both banks in one cycle
    mon_n = 0;
    send(0, 3'd5, 4'd2, 1'b0, 1'b0);
    send(1, 3'd6, 4'd4, 1'b1, 1'b0);
    @(negedge clk);
    idle_inputs();
    chk("R12 dual ack", 128'(rd_ack), 128'(2'b11));
    repeat (16) @(negedge clk);
    chk("R10 beat count", 128'(mon_n), 128'(8));
    for (int i = 0; i < 8; i++) begin
      chk("R10 bank order", 128'(mon_bank[i]), 128'(i < 4 ? 0 : 1));
      chk("R6 no interleave tag", 128'(mon_tag[i]), 128'(i < 4 ? 5 : 6));
    end

    // Tag reuse after completion
    send(0, 3'd5, 4'd1, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    chk("R6 tag freed", 128'(rd_ack), 128'(2'b01));
    repeat (14) @(negedge clk);

    // Duplicate tag
    mon_n = 0;
    send(0, 3'd2, 4'd7, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    repeat (4) @(negedge clk);
    send(0, 3'd2, 4'd8, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    chk("R3 dup err", 128'(proto_err), 128'(2'b01));
    chk("R3 dup no ack", 128'(rd_ack), 128'(0));
    repeat (14) @(negedge clk);
    chk("R3 dup not served", 128'(mon_n), 128'(4));

    // Minimum gap
    send(0, 3'd1, 4'd1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R11 first ack", 128'(rd_ack), 128'(2'b01));
    send(0, 3'd3, 4'd1, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    chk("R11 gap err", 128'(proto_err), 128'(2'b01));
    chk("R11 gap no ack", 128'(rd_ack), 128'(0));
    repeat (14) @(negedge clk);

    // Cap: bank 0 saturates the engine, bank 1 fills all tags
    mon_n = 0;
    for (int i = 0; i < 9; i++) begin
      send(0, 3'(i % 8), 4'(i), 1'b0, 1'b0);
      send(1, 3'((i + 3) % 8), 4'(i + 5), 1'b0, 1'(i % 2));
      @(negedge clk);
      idle_inputs();
      chk("R2 bank0 ack", 128'(rd_ack[0]), 128'(1));
      if (i < 8) chk("R2 bank1 ack", 128'(rd_ack[1]), 128'(1));
      else begin
        chk("R2 ninth err", 128'(proto_err[1]), 128'(1));
        chk("R2 ninth no ack", 128'(rd_ack[1]), 128'(0));
      end
      repeat (3) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    chk("R2 total beats", 128'(mon_n), 128'(68));
    chk("R10 bank0 first", 128'(mon_bank[0]), 128'(0));
    base = 36;
    chk("R10 bank1 starved", 128'(mon_bank[base - 1]), 128'(0));
    for (int j = 0; j < 8; j++) begin
      chk("R2 bank1 drain bank", 128'(mon_bank[base + 4*j]), 128'(1));
      chk("R2 bank1 drain tag", 128'(mon_tag[base + 4*j]), 128'((j + 3) % 8));
      if (j % 2 == 1) chk("R7 dummy beat", mon_data[base + 4*j + 2], 128'(0));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule